// File: doc/BRIEF.md
# Issue Queue Operand Wakeup Scoreboard

This block tracks when the operands of instructions held in an out-of-order issue queue become available. It holds one readiness flag for every physical register, integer and floating-point together. Each queue entry records two source tags and whether each source is ready. When an instruction is written into a queue slot, every source that rename did not already mark as ready is looked up in the flag array. A completion broadcast of the same tag in that cycle is forwarded to the incoming entry. The new instruction's destination register has its flag cleared, because that instruction is now the register's pending producer.

A completing producer broadcasts its destination tag. The flag for that register is set, and every waiting source in every slot with a matching tag becomes ready in the same cycle. Each slot reports that it may issue once all of its sources are ready. A credit counter of free slots drives a full indication. Two error pulses flag misuse: an insert attempted with no free slot, and a producer claiming a register that some entry is still waiting on. Slot choice and the select policy belong to the surrounding queue.

Top module: `iq_wakeup_sb`

## Requirements
- R1: After a synchronous reset, every register flag reads not-ready, no slot is valid or issue-ready, the free count equals the number of slots, full is low, and both error pulses are low.
- R2: A source inserted with its rename-time ready flag set is ready in the slot, whatever the register flag holds.
- R3: A source inserted without the rename flag is ready when its register flag is set, or when an in-range completion of the same tag arrives in the same cycle; otherwise it waits.
- R4: An accepted insert with a valid in-range destination clears that register's flag, even if a completion of the same tag arrives in the same cycle, so later consumers of it wait.
- R5: An in-range completion sets the register's flag and, one clock later, marks ready every waiting source in any valid slot whose tag matches.
- R6: A completion tag equal to or above the tracked register count (integer plus floating) changes no flag and wakes no source.
- R7: A slot's issue-ready bit is high exactly when the slot is valid and both its sources are ready, and it reflects an insert or wakeup from the following cycle on.
- R8: The free count falls by one on each accepted insert and rises by one on each issue of a valid slot; full is high exactly when the count is zero.
- R9: An insert while the free count is zero is dropped (no slot, flag or count changes), and the overflow error pulses high for one cycle after it.
- R10: An accepted insert whose valid in-range destination equals the tag of a source still waiting in a valid slot, and not being woken in that cycle, raises the chain error pulse for one cycle after it.
- R11: An issue of a slot clears its valid bit on the next cycle, unless the same slot is written by an insert in that cycle.
- R12: Each valid slot presents the 2-bit class value it was inserted with (0 integer, 1 floating, 2 control).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_slot | input | SLOT_W | Slot written by the insert (must be free) |
| ins_src0_tag | input | TAG_W | First source register tag |
| ins_src0_rdy | input | 1 | First source ready at rename |
| ins_src1_tag | input | TAG_W | Second source register tag |
| ins_src1_rdy | input | 1 | Second source ready at rename |
| ins_dst_valid | input | 1 | Insert has a destination register |
| ins_dst_tag | input | TAG_W | Destination register tag |
| ins_class | input | 2 | Instruction class |
| cmp_valid | input | 1 | Completion broadcast valid |
| cmp_tag | input | TAG_W | Completed destination tag |
| iss_valid | input | 1 | A slot is issued this cycle |
| iss_slot | input | SLOT_W | Slot being issued |
| entry_valid | output | NUM_ENTRIES | Slot occupied |
| entry_ready | output | NUM_ENTRIES | Slot has all operands ready |
| entry_class | output | 2*NUM_ENTRIES | Class of each slot, slot i at bits 2i+1:2i |
| free_count | output | CNT_W | Free slots |
| full | output | 1 | No free slot |
| err_overflow | output | 1 | Insert attempted while full |
| err_chain | output | 1 | Producer claimed a register with waiting consumers |

## Verification
The bench builds the block with four slots, eight integer plus eight floating registers, and 5-bit tags. Four slots make full and overflow reachable within a few inserts. Sixteen tracked registers under a 5-bit tag leave tags 16 to 31 out of range, and tag 20 aliases register 4 under truncation, so a wrongly handled out-of-range completion wakes a waiting consumer. Directed sequences cover same-cycle forwarding and producer claims. A long random run of mixed inserts, issues and completions then compares every output against a cycle model.

// File: rtl/iqsb_pkg.sv
package iqsb_pkg;
  localparam int CLS_W = 2;
  localparam int SRCS  = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_CTRL = 2'd2
  } op_class_e;
endpackage

// File: rtl/iqsb_flags.sv
module iqsb_flags #(
  parameter int NUM_PREGS = 16,
  localparam int SB_W = $clog2(NUM_PREGS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          set_v,
  input  logic [SB_W-1:0]               set_tag,
  input  logic                          clr_v,
  input  logic [SB_W-1:0]               clr_tag,
  input  logic [iqsb_pkg::SRCS-1:0]     rd_ok,
  input  logic [iqsb_pkg::SRCS-1:0][SB_W-1:0] rd_tag,
  output logic [iqsb_pkg::SRCS-1:0]     rd_rdy
);
  logic [NUM_PREGS-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
    end else begin
      if (set_v) flag_q[set_tag] <= 1'b1;
      if (clr_v) flag_q[clr_tag] <= 1'b0;
    end
  end

  for (genvar k = 0; k < iqsb_pkg::SRCS; k++) begin : g_rd
    assign rd_rdy[k] = rd_ok[k] &&
                       (flag_q[rd_tag[k]] || (set_v && set_tag == rd_tag[k]));
  end

  assert_claim_clears_R4: assert property (@(posedge clk) disable iff (rst)
    clr_v |=> !flag_q[$past(clr_tag)]);

  assert_done_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (set_v && !(clr_v && clr_tag == set_tag)) |=> flag_q[$past(set_tag)]);
endmodule

// File: rtl/iqsb_entry.sv
module iqsb_entry #(
  parameter int TAG_W = 5
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     wr_en,
  input  logic [iqsb_pkg::SRCS-1:0][TAG_W-1:0]     wr_tag,
  input  logic [iqsb_pkg::SRCS-1:0]                wr_rdy,
  input  logic [iqsb_pkg::CLS_W-1:0]               wr_cls,
  input  logic                                     kill,
  input  logic                                     wk_valid,
  input  logic [TAG_W-1:0]                         wk_tag,
  output logic                                     valid_o,
  output logic                                     ready_o,
  output logic [iqsb_pkg::CLS_W-1:0]               cls_o,
  output logic [iqsb_pkg::SRCS-1:0]                pend_o,
  output logic [iqsb_pkg::SRCS-1:0][TAG_W-1:0]     tag_o
);
  logic                                 valid_q;
  logic [iqsb_pkg::SRCS-1:0]            rdy_q;
  logic [iqsb_pkg::SRCS-1:0][TAG_W-1:0] tag_q;
  logic [iqsb_pkg::CLS_W-1:0]           cls_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      rdy_q   <= '0;
      tag_q   <= '0;
      cls_q   <= '0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
      rdy_q   <= wr_rdy;
      tag_q   <= wr_tag;
      cls_q   <= wr_cls;
    end else begin
      if (kill) valid_q <= 1'b0;
      for (int k = 0; k < iqsb_pkg::SRCS; k++) begin
        if (valid_q && wk_valid && tag_q[k] == wk_tag) rdy_q[k] <= 1'b1;
      end
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q && (&rdy_q);
  assign cls_o   = cls_q;
  assign pend_o  = {iqsb_pkg::SRCS{valid_q}} & ~rdy_q;
  assign tag_o   = tag_q;

  assert_wake_src0_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !wr_en && wk_valid && tag_q[0] == wk_tag) |=> rdy_q[0]);

  assert_wake_src1_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !wr_en && wk_valid && tag_q[1] == wk_tag) |=> rdy_q[1]);

  assert_ready_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> ($past(wr_en) || $past(wk_valid)));

  assert_issue_frees_R11: assert property (@(posedge clk) disable iff (rst)
    (kill && !wr_en) |=> !valid_o);
endmodule

// File: rtl/iqsb_credit.sv
module iqsb_credit #(
  parameter int NUM_ENTRIES = 4,
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             give,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(NUM_ENTRIES);
    end else if (give && !take) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (take && !give) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(NUM_ENTRIES));

  assert_take_step_R8: assert property (@(posedge clk) disable iff (rst)
    (take && !give) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/iq_wakeup_sb.sv
module iq_wakeup_sb #(
  parameter int NUM_ENTRIES = 4,
  parameter int INT_PREGS   = 8,
  parameter int FP_PREGS    = 8,
  parameter int TAG_W       = 5,
  localparam int NUM_PREGS  = INT_PREGS + FP_PREGS,
  localparam int SB_W       = $clog2(NUM_PREGS),
  localparam int SLOT_W     = $clog2(NUM_ENTRIES),
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1),
  localparam int CLS_W      = iqsb_pkg::CLS_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ins_valid,
  input  logic [SLOT_W-1:0]            ins_slot,
  input  logic [TAG_W-1:0]             ins_src0_tag,
  input  logic                         ins_src0_rdy,
  input  logic [TAG_W-1:0]             ins_src1_tag,
  input  logic                         ins_src1_rdy,
  input  logic                         ins_dst_valid,
  input  logic [TAG_W-1:0]             ins_dst_tag,
  input  logic [CLS_W-1:0]             ins_class,
  input  logic                         cmp_valid,
  input  logic [TAG_W-1:0]             cmp_tag,
  input  logic                         iss_valid,
  input  logic [SLOT_W-1:0]            iss_slot,
  output logic [NUM_ENTRIES-1:0]       entry_valid,
  output logic [NUM_ENTRIES-1:0]       entry_ready,
  output logic [NUM_ENTRIES*CLS_W-1:0] entry_class,
  output logic [CNT_W-1:0]             free_count,
  output logic                         full,
  output logic                         err_overflow,
  output logic                         err_chain
);
  localparam int SRCS = iqsb_pkg::SRCS;

  logic cmp_ok, dst_ok, accept, claim, give;
  logic [SRCS-1:0]            src_ok, flag_rdy, src_rdy;
  logic [SRCS-1:0][TAG_W-1:0] src_tag;
  logic [SRCS-1:0][SB_W-1:0]  src_idx;
  logic [SRCS-1:0]            ren_rdy;

  logic [NUM_ENTRIES-1:0]                  chain_hit;
  logic [NUM_ENTRIES-1:0][SRCS-1:0]        pend;
  logic [NUM_ENTRIES-1:0][SRCS-1:0][TAG_W-1:0] etag;

  assign cmp_ok  = cmp_valid && (int'(cmp_tag) < NUM_PREGS);
  assign dst_ok  = ins_dst_valid && (int'(ins_dst_tag) < NUM_PREGS);
  assign accept  = ins_valid && !full;
  assign claim   = accept && dst_ok;
  assign give    = iss_valid && entry_valid[iss_slot];

  assign src_tag = {ins_src1_tag, ins_src0_tag};
  assign ren_rdy = {ins_src1_rdy, ins_src0_rdy};

  for (genvar k = 0; k < SRCS; k++) begin : g_src
    assign src_ok[k]  = int'(src_tag[k]) < NUM_PREGS;
    assign src_idx[k] = src_tag[k][SB_W-1:0];
    assign src_rdy[k] = ren_rdy[k] || flag_rdy[k];
  end

  iqsb_flags #(.NUM_PREGS(NUM_PREGS)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_v   (cmp_ok),
    .set_tag (cmp_tag[SB_W-1:0]),
    .clr_v   (claim),
    .clr_tag (ins_dst_tag[SB_W-1:0]),
    .rd_ok   (src_ok),
    .rd_tag  (src_idx),
    .rd_rdy  (flag_rdy)
  );

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    iqsb_entry #(.TAG_W(TAG_W)) u_ent (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (accept && ins_slot == SLOT_W'(i)),
      .wr_tag   (src_tag),
      .wr_rdy   (src_rdy),
      .wr_cls   (ins_class),
      .kill     (iss_valid && iss_slot == SLOT_W'(i)),
      .wk_valid (cmp_ok),
      .wk_tag   (cmp_tag),
      .valid_o  (entry_valid[i]),
      .ready_o  (entry_ready[i]),
      .cls_o    (entry_class[i*CLS_W +: CLS_W]),
      .pend_o   (pend[i]),
      .tag_o    (etag[i])
    );

    always_comb begin
      chain_hit[i] = 1'b0;
      for (int k = 0; k < SRCS; k++) begin
        if (pend[i][k] && etag[i][k] == ins_dst_tag &&
            !(cmp_ok && cmp_tag == etag[i][k]))
          chain_hit[i] = 1'b1;
      end
    end
  end

  iqsb_credit #(.NUM_ENTRIES(NUM_ENTRIES)) u_credit (
    .clk     (clk),
    .rst     (rst),
    .take    (accept),
    .give    (give),
    .count_o (free_count),
    .empty_o (full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_overflow <= 1'b0;
      err_chain    <= 1'b0;
    end else begin
      err_overflow <= ins_valid && full;
      err_chain    <= claim && (|chain_hit);
    end
  end

  assert_overflow_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && full) |=> err_overflow);

  assert_overflow_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && full && !give) |=> (free_count == '0));

  assert_chain_cause_R10: assert property (@(posedge clk) disable iff (rst)
    err_chain |-> $past(ins_valid && ins_dst_valid));
endmodule

// File: tb/iq_wakeup_sb_test.sv
module iq_wakeup_sb_test;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int NP = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       ins_valid = 0, ins_src0_rdy = 0, ins_src1_rdy = 0, ins_dst_valid = 0;
  logic [1:0] ins_slot = 0, iss_slot = 0, ins_class = 0;
  logic [4:0] ins_src0_tag = 0, ins_src1_tag = 0, ins_dst_tag = 0, cmp_tag = 0;
  logic       cmp_valid = 0, iss_valid = 0;
  logic [NE-1:0]   entry_valid, entry_ready;
  logic [2*NE-1:0] entry_class;
  logic [2:0]      free_count;
  logic            full, err_overflow, err_chain;

  iq_wakeup_sb uut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_slot(ins_slot),
    .ins_src0_tag(ins_src0_tag), .ins_src0_rdy(ins_src0_rdy),
    .ins_src1_tag(ins_src1_tag), .ins_src1_rdy(ins_src1_rdy),
    .ins_dst_valid(ins_dst_valid), .ins_dst_tag(ins_dst_tag), .ins_class(ins_class),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .iss_valid(iss_valid), .iss_slot(iss_slot),
    .entry_valid(entry_valid), .entry_ready(entry_ready), .entry_class(entry_class),
    .free_count(free_count), .full(full), .err_overflow(err_overflow), .err_chain(err_chain)
  );

  int checks = 0, errors = 0;
  bit m_sb[NP];
  bit m_v[NE], m_r0[NE], m_r1[NE];
  int m_t0[NE], m_t1[NE], m_c[NE];
  int m_cnt;
  bit m_eo, m_ec;

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit src_ready(bit flag, int tag, bit hit, int ct);
    if (flag) return 1'b1;
    if (tag >= NP) return 1'b0;
    return m_sb[tag] || (hit && ct == tag);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NP; i++) m_sb[i] = 0;
    for (int i = 0; i < NE; i++) begin
      m_v[i] = 0; m_r0[i] = 0; m_r1[i] = 0; m_t0[i] = 0; m_t1[i] = 0; m_c[i] = 0;
    end
    m_cnt = NE; m_eo = 0; m_ec = 0;
  endtask

  task automatic model_step();
    bit hit, acc, dok, chain, inc, r0, r1;
    int ct, dt;
    ct  = int'(cmp_tag);
    dt  = int'(ins_dst_tag);
    hit = cmp_valid && ct < NP;
    acc = ins_valid && m_cnt != 0;
    dok = ins_dst_valid && dt < NP;
    r0  = src_ready(ins_src0_rdy, int'(ins_src0_tag), hit, ct);
    r1  = src_ready(ins_src1_rdy, int'(ins_src1_tag), hit, ct);
    chain = 0;
    for (int i = 0; i < NE; i++) begin
      if (m_v[i] && !m_r0[i] && m_t0[i] == dt && !(hit && ct == m_t0[i])) chain = 1;
      if (m_v[i] && !m_r1[i] && m_t1[i] == dt && !(hit && ct == m_t1[i])) chain = 1;
    end
    inc  = iss_valid && m_v[iss_slot];
    m_eo = ins_valid && m_cnt == 0;
    m_ec = acc && dok && chain;
    for (int i = 0; i < NE; i++) begin
      if (acc && int'(ins_slot) == i) begin
        m_v[i] = 1; m_r0[i] = r0; m_r1[i] = r1;
        m_t0[i] = int'(ins_src0_tag); m_t1[i] = int'(ins_src1_tag); m_c[i] = int'(ins_class);
      end else begin
        if (m_v[i] && hit && m_t0[i] == ct) m_r0[i] = 1;
        if (m_v[i] && hit && m_t1[i] == ct) m_r1[i] = 1;
        if (iss_valid && int'(iss_slot) == i) m_v[i] = 0;
      end
    end
    if (hit) m_sb[ct] = 1;
    if (acc && dok) m_sb[dt] = 0;
    m_cnt = m_cnt + int'(inc) - int'(acc);
  endtask

  task automatic compare_all();
    for (int i = 0; i < NE; i++) begin
      chk(entry_valid[i], m_v[i], "R11 entry_valid");
      chk(entry_ready[i], m_v[i] && m_r0[i] && m_r1[i], "R7 entry_ready");
      if (m_v[i]) chk(entry_class[2*i +: 2], m_c[i], "R12 entry_class");
    end
    chk(free_count, m_cnt, "R8 free_count");
    chk(full, m_cnt == 0, "R8 full");
    chk(err_overflow, m_eo, "R9 err_overflow");
    chk(err_chain, m_ec, "R10 err_chain");
  endtask

  task automatic idle();
    ins_valid = 0; cmp_valid = 0; iss_valid = 0; ins_dst_valid = 0;
    ins_src0_rdy = 0; ins_src1_rdy = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic set_ins(int slot, int t0, bit f0, int t1, bit f1, int dst, bit dv, int cls);
    ins_valid = 1; ins_slot = 2'(slot);
    ins_src0_tag = 5'(t0); ins_src0_rdy = f0;
    ins_src1_tag = 5'(t1); ins_src1_rdy = f1;
    ins_dst_tag = 5'(dst); ins_dst_valid = dv; ins_class = 2'(cls);
  endtask

  task automatic put(int slot, int t0, bit f0, int t1, bit f1, int dst, bit dv, int cls);
    set_ins(slot, t0, f0, t1, f1, dst, dv, cls);
    tick();
  endtask

  task automatic done(int tag);
    cmp_valid = 1; cmp_tag = 5'(tag);
    tick();
  endtask

  task automatic pull(int slot);
    iss_valid = 1; iss_slot = 2'(slot);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(entry_valid, 0, "R1 valid");
    chk(entry_ready, 0, "R1 ready");
    chk(free_count, NE, "R1 free_count");
    chk(full, 0, "R1 full");
    chk(err_overflow | err_chain, 0, "R1 errors");

    put(0, 3, 1, 3, 1, 0, 0, 1);
    chk(entry_ready[0], 1, "R2 rename-ready sources");
    chk(free_count, 3, "R8 decrement");
    chk(entry_class[1:0], 1, "R12 class");
    pull(0);
    chk(entry_valid[0], 0, "R11 issue clears");
    chk(free_count, 4, "R8 increment");
    done(5);
    put(1, 5, 0, 5, 0, 0, 0, 0);
    chk(entry_ready[1], 1, "R3 flag lookup");
    cmp_valid = 1; cmp_tag = 5'd6;
    set_ins(2, 6, 0, 6, 0, 0, 0, 2);
    tick();
    chk(entry_ready[2], 1, "R3 same-cycle forward");
    put(3, 0, 1, 0, 1, 5, 1, 0);
    chk(err_chain, 0, "R10 no waiter");
    pull(1); pull(2); pull(3);
    put(0, 5, 0, 7, 1, 0, 0, 0);
    chk(entry_ready[0], 0, "R4 claimed register waits");
    put(1, 4, 0, 4, 0, 0, 0, 0);
    done(20);
    chk(entry_ready[1], 0, "R6 out-of-range completion ignored");
    done(5);
    chk(entry_ready[0], 1, "R5 wakeup");
    done(4);
    chk(entry_ready[1], 1, "R5 wakeup both sources");
    pull(0); pull(1);
    put(0, 9, 0, 9, 1, 0, 0, 0);
    put(1, 0, 1, 0, 1, 9, 1, 0);
    chk(err_chain, 1, "R10 chain error");
    put(2, 0, 1, 0, 1, 0, 0, 0);
    chk(err_chain, 0, "R10 pulse ends");
    put(3, 0, 1, 0, 1, 0, 0, 0);
    chk(full, 1, "R8 full");
    put(0, 0, 1, 0, 1, 0, 0, 0);
    chk(err_overflow, 1, "R9 overflow");
    chk(entry_ready[0], 0, "R9 dropped insert");
    chk(free_count, 0, "R9 count unchanged");
    // R4: same-cycle completion and claim of one register
    pull(2);
    cmp_valid = 1; cmp_tag = 5'd11;
    set_ins(2, 0, 1, 0, 1, 11, 1, 0);
    tick();
    pull(3);
    put(3, 11, 0, 11, 0, 0, 0, 0);
    chk(entry_ready[3], 0, "R4 claim beats completion");

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 1) == 1) begin
        int slot;
        slot = -1;
        for (int i = 0; i < NE; i++) if (!m_v[i] && slot < 0) slot = i;
        if (slot < 0) slot = int'($urandom_range(0, NE-1));
        set_ins(slot, int'($urandom_range(0, NP-1)), 1'($urandom_range(0, 3) == 0),
                int'($urandom_range(0, NP-1)), 1'($urandom_range(0, 3) == 0),
                int'($urandom_range(0, NP+3)), 1'($urandom_range(0, 1)),
                int'($urandom_range(0, 2)));
      end
      if ($urandom_range(0, 2) != 0) begin
        cmp_valid = 1; cmp_tag = 5'($urandom_range(0, 19));
      end
      if ($urandom_range(0, 2) == 0) begin
        iss_valid = 1; iss_slot = 2'($urandom_range(0, NE-1));
        if (ins_valid && ins_slot == iss_slot) iss_valid = 0;
      end
      tick();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule